// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Array

This block models a small programmable sum-of-products logic device. Eight logic inputs and eight register feedback lines form a 16-signal array, and each signal is available in true and complement form. Sixty-four product terms, eight per output cell, are built from that array. Each of the eight output cells is set to one of two modes. In registered mode the cell ORs all eight of its terms into a flip-flop. In combinational mode one term acts as a per-cell output enable and the other seven are ORed. In both modes the output is driven inverted.

The whole configuration is a single serial shift chain, loaded while a program-enable input is high. It holds the term connections, the cell modes and a power-down enable. When power-down is enabled, input bit 3 stops being a logic input and becomes a power-down request. While power-down is active, the outputs hold both their values and their enables. The clock, the inputs and the output enable then have no effect. Tri-state behaviour is shown on separate value and enable outputs for each cell.

Top module: `pal_array_top`

## Requirements
- R1: A product term is the AND of every literal whose configuration bit is 1. The bit for signal s in true form of term t sits at index t*32+2*s, and its complement form sits at t*32+2*s+1, where term t = cell*8 + term number. A term with no bit set evaluates to 1. A term with both polarities of one signal set evaluates to 0, so a chain of all ones makes every term 0.
- R2: A cell in registered mode (mode bit 1) loads the OR of its eight terms on each rising clock edge. Its output value is the inverted register, and it is enabled exactly when oe_n is low.
- R3: A cell in combinational mode (mode bit 0) uses term 0 as its output enable. Its output value is the inverted OR of terms 1 to 7, and its register is cleared to 0 on every active edge.
- R4: Array signals 0 to 7 are data_in[7:0]. Signals 8 to 15 are the registers of cells 0 to 7, fed back into the array.
- R5: Synchronous active-low reset clears every register, sets every configuration bit to 1 except the power-down enable, which is cleared, and clears the power-down state. With oe_n low, all outputs then read 1 and are enabled.
- R6: While prog_en is high, each rising edge shifts prog_din into configuration bit 0 and moves every bit up one place. Bits 0 to 2047 are term connections, bit 2048+m is the mode of cell m, and bit 2056 is the power-down enable. During loading every out_en bit is 0 and the registers keep their values.
- R7: With the power-down enable at 0, data_in[3] is an ordinary array input. With it at 1, the array sees signal 3 as 0, and data_in[3] high is a power-down request.
- R8: Power-down begins at the first rising edge that sees the request high. From that edge on, out_val and out_en keep the values they had just before that edge, and the registers do not change, whatever the clock, data_in and oe_n do.
- R9: At the first rising edge that sees the request low again, the outputs return at once to values computed from the current inputs and registers. The registers update again from the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for registers, power-down state and configuration chain |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | High while the configuration chain is shifted |
| prog_din | input | 1 | Serial configuration bit |
| data_in | input | 8 | Logic inputs; bit 3 doubles as power-down request |
| oe_n | input | 1 | Active-low output enable for registered cells |
| out_val | output | 8 | Output value of each cell |
| out_en | output | 8 | Drive enable of each cell (0 means high impedance) |

## Verification
The hardest situation to reach is a power-down entered or left while a mix of registered and combinational cells is active with state in feedback. To reach it, the stimulus first loads a 2057-bit chain with mixed modes and power-down enabled. It then runs random inputs with feedback-driven terms, and toggles data_in[3] in bursts of random length while the clock keeps running and the other inputs and oe_n change. A bench model tracks the frozen state and the one-edge delay before registers resume. Exhaustive input sweeps on a purely combinational configuration cover the term logic, including the double-polarity and empty-term cases.

// File: rtl/pal_pkg.sv
// Package: shared defaults and the macrocell mode encoding for the logic array.
// Assumes: one mode bit per cell, 1 selects the registered variant.
package pal_pkg;
    localparam int DEF_N_IN  = 8;
    localparam int DEF_N_MC  = 8;
    localparam int DEF_N_PT  = 8;

    typedef enum logic {
        MC_COMB = 1'b0,
        MC_REG  = 1'b1
    } mc_mode_e;
endpackage

// File: rtl/pal_cfg_chain.sv
// Configuration shift chain: holds term connections, cell modes and the
// power-down enable. Assumes: bit 0 receives serial data, MSB is the
// power-down enable, and reset restores an all-connected registered device.
module pal_cfg_chain #(
    parameter int CFG_W = 2057
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             prog_din,
    output logic [CFG_W-1:0] cfg
);
    localparam logic [CFG_W-1:0] CFG_RESET = {1'b0, {(CFG_W-1){1'b1}}};

    // Shift one configuration bit in per edge while programming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RESET;
        else if (prog_en)
            cfg <= {cfg[CFG_W-2:0], prog_din};
    end

    // R6
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> cfg[0] == $past(prog_din));
endmodule

// File: rtl/pal_and_array.sv
// Product-term array: every term ANDs the literals whose connection bit is
// set. Assumes: two connection bits per signal per term, true form at the
// even index, complement at the odd one.
module pal_and_array #(
    parameter int N_SIG   = 16,
    parameter int N_TERMS = 64
) (
    input  logic [N_TERMS*2*N_SIG-1:0] fuses,
    input  logic [N_SIG-1:0]           sig,
    output logic [N_TERMS-1:0]         pt
);
    localparam int PT_FUSES = 2 * N_SIG;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_SIG-1:0] lit_ok;
        for (genvar s = 0; s < N_SIG; s++) begin : g_sig
            // A literal passes unless its connection demands the other level.
            assign lit_ok[s] = (~fuses[t*PT_FUSES + 2*s]     |  sig[s]) &
                               (~fuses[t*PT_FUSES + 2*s + 1] | ~sig[s]);
        end
        assign pt[t] = &lit_ok;
    end
endmodule

// File: rtl/pal_macrocell.sv
// Output macrocell: registered or combinational sum, inverted output, enable
// selection and power-down hold. Assumes freeze already merges the raw
// request and the power-down state, and pd_q is the registered state.
module pal_macrocell #(
    parameter int N_PT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              freeze,
    input  logic              pd_q,
    input  pal_pkg::mc_mode_e mode,
    input  logic              oe_n,
    input  logic [N_PT-1:0]   pt,
    output logic              q,
    output logic              pin_val,
    output logic              pin_en
);
    import pal_pkg::*;

    logic sum_all, sum_tail, live_val, live_en, hold_val, hold_en;

    // OR of all terms for registered use, of terms 1.. for combinational use.
    always_comb begin
        sum_all  = |pt;
        sum_tail = |pt[N_PT-1:1];
    end

    // Live output value and enable for the selected mode.
    always_comb begin
        live_val = (mode == MC_REG) ? ~q : ~sum_tail;
        live_en  = !prog_en && ((mode == MC_REG) ? !oe_n : pt[0]);
    end

    // State register: advances only outside programming and power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (!prog_en && !freeze)
            q <= (mode == MC_REG) ? sum_all : 1'b0;
    end

    // Hold copy of the pin, captured each edge until power-down is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_val <= 1'b1;
            hold_en  <= 1'b0;
        end else if (!pd_q) begin
            hold_val <= live_val;
            hold_en  <= live_en;
        end
    end

    // Pin selection between live and held values.
    always_comb begin
        pin_val = pd_q ? hold_val : live_val;
        pin_en  = prog_en ? 1'b0 : (pd_q ? hold_en : live_en);
    end

    // R8
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q && $past(pd_q) && !prog_en && !$past(prog_en)) |->
        (pin_val == $past(pin_val) && pin_en == $past(pin_en)));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0 && hold_en == 1'b0));

    // R3
    comb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MC_COMB && $past(mode) == MC_COMB && !$past(prog_en) && !$past(freeze))
        |-> q == 1'b0);
endmodule

// File: rtl/pal_array_top.sv
// Top of the programmable logic array: configuration chain, product-term
// array, power-down control and the output macrocells.
// Assumes: data_in[DUAL_IDX] is the dual-use pin; outputs are shown as
// value/enable pairs instead of tri-state pins.
module pal_array_top #(
    parameter int N_IN     = pal_pkg::DEF_N_IN,
    parameter int N_MC     = pal_pkg::DEF_N_MC,
    parameter int N_PT     = pal_pkg::DEF_N_PT,
    parameter int DUAL_IDX = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_en,
    input  logic            prog_din,
    input  logic [N_IN-1:0] data_in,
    input  logic            oe_n,
    output logic [N_MC-1:0] out_val,
    output logic [N_MC-1:0] out_en
);
    import pal_pkg::*;

    localparam int N_SIG   = N_IN + N_MC;
    localparam int N_TERMS = N_MC * N_PT;
    localparam int FUSE_W  = N_TERMS * 2 * N_SIG;
    localparam int CFG_W   = FUSE_W + N_MC + 1;

    logic [CFG_W-1:0]   cfg;
    logic [N_TERMS-1:0] pt;
    logic [N_MC-1:0]    q;
    logic [N_IN-1:0]    in_eff;
    logic [N_SIG-1:0]   sig;
    logic               pd_en, pd_req, pd_q, freeze;

    pal_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_din(prog_din), .cfg(cfg)
    );

    // Dual-use pin decode and array signal assembly.
    always_comb begin
        pd_en  = cfg[CFG_W-1];
        pd_req = pd_en && data_in[DUAL_IDX];
        in_eff = data_in;
        if (pd_en)
            in_eff[DUAL_IDX] = 1'b0;
        sig    = {q, in_eff};
        freeze = pd_req || pd_q;
    end

    // Power-down state, sampled on each edge outside programming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_q <= 1'b0;
        else
            pd_q <= pd_req && !prog_en;
    end

    pal_and_array #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_array (
        .fuses(cfg[FUSE_W-1:0]), .sig(sig), .pt(pt)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_cell
        pal_macrocell #(.N_PT(N_PT)) u_cell (
            .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .freeze(freeze),
            .pd_q(pd_q), .mode(mc_mode_e'(cfg[FUSE_W + m])), .oe_n(oe_n),
            .pt(pt[m*N_PT +: N_PT]), .q(q[m]),
            .pin_val(out_val[m]), .pin_en(out_en[m])
        );
    end

    // R6
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> out_en == '0);
endmodule

// File: tb/tb_pal_array_top.sv
module tb_pal_array_top;
    localparam int NS = 16;
    localparam int FW = 8 * 8 * NS * 2;
    localparam int CW = FW + 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic       prog_din = 1'b0;
    logic [7:0] data_in = '0;
    logic       oe_n = 1'b0;
    logic [7:0] out_val, out_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    logic [CW-1:0] bcfg;
    logic [7:0] mq, mhv, mhe;
    logic mpdq, last_pdq;

    pal_array_top dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_din(prog_din),
        .data_in(data_in), .oe_n(oe_n), .out_val(out_val), .out_en(out_en)
    );

    always #10 clk = ~clk;

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    // Expected product term from the connection layout (R1, R4, R7).
    function automatic bit ptv(int m, int p, logic [7:0] din, logic [7:0] qv);
        logic [15:0] sg;
        bit r = 1;
        logic [7:0] d = din;
        if (bcfg[CW-1]) d[3] = 1'b0;
        sg = {qv, d};
        for (int s = 0; s < NS; s++) begin
            if (bcfg[((m*8+p)*NS+s)*2]   && !sg[s]) r = 0;
            if (bcfg[((m*8+p)*NS+s)*2+1] &&  sg[s]) r = 0;
        end
        return r;
    endfunction

    task automatic chk8(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_cycle(logic [7:0] din, logic oen, string tag);
        logic [7:0] lv, le, ev, ee, sa;
        string t;
        data_in = din;
        oe_n = oen;
        #5;
        for (int m = 0; m < 8; m++) begin
            bit s_all = 0, s_tail = 0;
            for (int p = 0; p < 8; p++) begin
                if (ptv(m, p, din, mq)) begin
                    s_all = 1;
                    if (p != 0) s_tail = 1;
                end
            end
            sa[m] = s_all;
            if (bcfg[FW+m]) begin
                lv[m] = ~mq[m];
                le[m] = ~oen;
            end else begin
                lv[m] = ~s_tail;
                le[m] = ptv(m, 0, din, mq);
            end
        end
        ev = mpdq ? mhv : lv;
        ee = mpdq ? mhe : le;
        t = mpdq ? "R8" : (last_pdq ? "R9" : tag);
        chk8(t, "out_en", out_en, ee);
        chk8(t, "out_val", out_val & ee, ev & ee);
        begin
            bit req = bcfg[CW-1] && din[3];
            last_pdq = mpdq;
            if (!(req || mpdq))
                for (int m = 0; m < 8; m++) mq[m] = bcfg[FW+m] ? sa[m] : 1'b0;
            if (!mpdq) begin
                mhv = lv;
                mhe = le;
            end
            mpdq = req;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg();
        prog_en = 1'b1;
        for (int i = CW - 1; i >= 0; i--) begin
            prog_din = bcfg[i];
            if (i == CW / 2) begin
                #5;
                // R6 outputs off while loading
                chk8("R6", "out_en during load", out_en, 8'h00);
            end
            @(negedge clk);
        end
        prog_en = 1'b0;
        mpdq = 1'b0;
        last_pdq = 1'b0;
    endtask

    task automatic gen_cfg(int nsig, logic [7:0] modes, logic pden);
        bcfg = '0;
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                int n;
                if (!modes[m] && p == 0 && (rnd() % 3 == 0)) continue;
                n = 2 + int'(rnd() % 3);
                for (int k = 0; k < n; k++) begin
                    int s = int'(rnd() % nsig);
                    int pol = int'(rnd() % 2);
                    bcfg[((m*8+p)*NS+s)*2+pol] = 1'b1;
                end
            end
            bcfg[FW+m] = modes[m];
        end
        bcfg[CW-1] = pden;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bcfg = {1'b0, {(CW-1){1'b1}}};
        mq = '0; mhv = '1; mhe = '0; mpdq = 0; last_pdq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R5 reset state
        chk8("R5", "out_en after reset", out_en, 8'hFF);
        chk8("R5", "out_val after reset", out_val, 8'hFF);
        @(negedge clk);
        // R1 unprogrammed chain: all terms zero
        for (int i = 0; i < 16; i++) run_cycle(8'(rnd()), 1'b0, "R1");

        // Combinational sweep, dual pin as input
        gen_cfg(8, 8'h00, 1'b0);
        load_cfg();
        run_cycle(8'h00, 1'b0, "R3");
        for (int v = 0; v < 256; v++) run_cycle(8'(v), 1'b1, "R3");
        for (int v = 0; v < 256; v += 8) run_cycle(8'(v) ^ 8'h08, 1'b0, "R7");

        // Registered with feedback
        gen_cfg(16, 8'hFF, 1'b0);
        load_cfg();
        for (int i = 0; i < 400; i++) run_cycle(8'(rnd()), (rnd() % 5) == 0, "R2");
        for (int i = 0; i < 100; i++) run_cycle(8'(rnd()), 1'b0, "R4");

        // Mixed modes with power-down bursts
        gen_cfg(16, 8'h55, 1'b1);
        load_cfg();
        for (int i = 0; i < 60; i++) run_cycle(8'(rnd()) & 8'hF7, 1'b0, "R7");
        for (int b = 0; b < 25; b++) begin
            int len_on = 1 + int'(rnd() % 6);
            int len_off = 1 + int'(rnd() % 5);
            for (int i = 0; i < len_on; i++) run_cycle(8'(rnd()) | 8'h08, rnd() % 2 == 1, "R8");
            for (int i = 0; i < len_off; i++) run_cycle(8'(rnd()) & 8'hF7, rnd() % 4 == 0, "R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule